// File: doc/BRIEF.md
# Dual-Mode Quad Storage Latch

A four-bit storage element in which every bit may behave either as a transparent data latch or as a set/reset latch. The mode is chosen purely by how that bit's active-low set input is driven. All four bits share one active-low enable and one active-low master reset. This is a clock-sampled model. The enable, data and set inputs are sampled on the rising edge of the system clock. The master reset clears storage at once and is released through a synchronizer.

While the enable is low, each bit follows a data-dominant rule:
- a low data input clears the bit;
- a low set input sets it only when data is high;
- both inputs high leave the bit unchanged.

While the enable is high, nothing changes. The master reset beats every other input.

A timing monitor measures the pulses on the enable and on the master reset in whole clock cycles. Each minimum is given in nanoseconds and rounded up to cycles using a clock-period parameter. The monitor also checks the recovery gap between leaving reset and the next enable activation. Each kind of violation has its own sticky flag, which stays set until the clear input is sampled high.

Top module: `quad_latch`

## Requirements
- R1: After the synchronous system reset `rst`, all of `q` reads 0 and all of `viol` reads 0.
- R2: When `en_n` is sampled high at an edge, no bit of `q` changes, whatever `d` and `set_n` hold.
- R3: With `en_n` and `set_n[i]` sampled low, `q[i]` takes the sampled `d[i]` after that edge.
- R4: With `en_n` low, `d[i]` high and `set_n[i]` low, `q[i]` becomes 1 after the edge.
- R5: With `en_n` low and both `d[i]` and `set_n[i]` low, data dominates and `q[i]` becomes 0 after the edge.
- R6: With `en_n` low and both `d[i]` and `set_n[i]` high, `q[i]` keeps its previous value.
- R7: A low on `mrst_n` forces every bit of `q` to 0 at once, without waiting for a clock edge, and overrides `en_n`, `d` and `set_n`.
- R8: After `mrst_n` rises, `q` stays 0 through the first two rising edges. The third edge is the first to apply the sampled inputs.
- R9: Bit 0 of `viol` is set when a low pulse on `en_n` lasts fewer sampled cycles than ceil(EN_MIN_NS / CLK_PERIOD_NS), which is 4 by default. The flag appears after the edge that first samples `en_n` high again. A pulse of exactly the minimum sets nothing.
- R10: Bit 1 of `viol` is set in the same way for a low pulse on `mrst_n` shorter than ceil(MR_MIN_NS / CLK_PERIOD_NS), which is 4 by default.
- R11: Bit 2 of `viol` is set when `en_n` is first sampled low while `mrst_n` is high and fewer than ceil(REC_NS / CLK_PERIOD_NS) high samples of `mrst_n` have been seen since it was low. That threshold is 1 by default, so the flag fires when both change before the same edge.
- R12: Each bit of `viol` is sticky. It stays set until `viol_clr` is sampled high at an edge, which clears all bits after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high system reset |
| mrst_n | input | 1 | Active-low master reset; clears storage asynchronously |
| en_n | input | 1 | Shared active-low enable |
| d | input | WIDTH | Per-bit data inputs |
| set_n | input | WIDTH | Per-bit active-low set inputs |
| viol_clr | input | 1 | Clears the sticky violation flags |
| q | output | WIDTH | Stored bits |
| viol | output | 3 | Sticky flags: bit 0 enable width, bit 1 reset width, bit 2 recovery |

## Verification
The hardest state to reach from the ports is a recovery violation. It needs `mrst_n` to rise and `en_n` to fall before the very same clock edge. The reset pulse must also be long enough that it does not itself trip the reset-width flag, so the two flags can be told apart. The stimulus holds the master reset low for the full minimum with the enable high. At one falling clock edge it then releases the reset and activates the enable together. A second run moves the enable one cycle later and expects no flag. A separate directed task drives the release edge with a set request already present and counts the edges before `q` first moves.

// File: rtl/quad_latch_pkg.sv
package quad_latch_pkg;

    // Indices of the sticky violation flags
    localparam int VIOL_W   = 3;
    localparam int VIOL_EN  = 0;
    localparam int VIOL_RST = 1;
    localparam int VIOL_REC = 2;

    // What a bit does at the next sampling edge
    typedef enum logic [1:0] {
        BIT_HOLD  = 2'd0,
        BIT_CLEAR = 2'd1,
        BIT_SET   = 2'd2
    } bit_act_e;

    // Sampled inputs seen by one storage bit
    typedef struct packed {
        logic en_n;
        logic d;
        logic set_n;
    } bit_in_t;

    // Nanoseconds to whole cycles, rounded up
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    // Data-dominant decode: a low data input wins over a low set input
    function automatic bit_act_e decode_bit(input bit_in_t in);
        bit_act_e act;
        if (in.en_n)
            act = BIT_HOLD;
        else if (!in.d)
            act = BIT_CLEAR;
        else if (!in.set_n)
            act = BIT_SET;
        else
            act = BIT_HOLD;
        return act;
    endfunction

    function automatic logic apply_act(input bit_act_e act, input logic cur);
        logic nxt;
        case (act)
            BIT_CLEAR: nxt = 1'b0;
            BIT_SET:   nxt = 1'b1;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/quad_latch_rst_sync.sv
module quad_latch_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic hold_o
);
    // Asynchronous assertion, synchronous release
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n)
                    chain <= 1'b1;
                else
                    chain <= 1'b0;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n)
                    chain <= '1;
                else
                    chain <= {chain[STAGES-2:0], 1'b0};
            end
        end
    endgenerate

    assign hold_o = chain[STAGES-1];

endmodule

// File: rtl/quad_latch_cell.sv
module quad_latch_cell
    import quad_latch_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clr_async,
    input  bit_in_t in_i,
    output logic    q_o
);
    bit_act_e act;

    assign act = decode_bit(in_i);

    always_ff @(posedge clk or posedge clr_async) begin
        if (clr_async)
            q_o <= 1'b0;
        else if (rst)
            q_o <= 1'b0;
        else
            q_o <= apply_act(act, q_o);
    end

    // R2
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (clr_async)
        (!rst && in_i.en_n) |=> $stable(q_o));

    // R5
    data_dominates_chk: assert property (@(posedge clk) disable iff (clr_async)
        (!rst && !in_i.en_n && !in_i.d) |=> !q_o);

    // R4
    set_when_data_high_chk: assert property (@(posedge clk) disable iff (clr_async)
        (!rst && !in_i.en_n && in_i.d && !in_i.set_n) |=> q_o);

endmodule

// File: rtl/quad_latch_pulse_chk.sv
module quad_latch_pulse_chk #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic level_n,
    output logic short_o
);
    localparam int CNT_W = $clog2(MIN_CYC + 2);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

    logic             prev_q;
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b1;
            low_cnt <= '0;
        end else begin
            prev_q <= level_n;
            if (!level_n) begin
                if (prev_q)
                    low_cnt <= CNT_W'(1);
                else if (low_cnt != MIN_V)
                    low_cnt <= low_cnt + CNT_W'(1);
            end
        end
    end

    // Pulse ends at this edge and was too short
    assign short_o = !rst && !prev_q && level_n && (low_cnt < MIN_V);

endmodule

// File: rtl/quad_latch_timing_mon.sv
module quad_latch_timing_mon
    import quad_latch_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int EN_MIN_NS     = 30,
    parameter int MR_MIN_NS     = 25,
    parameter int REC_NS        = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              mrst_n,
    input  logic              viol_clr,
    output logic [VIOL_W-1:0] viol_o
);
    localparam int EN_MIN_CYC = int'(ns_to_cycles(EN_MIN_NS, CLK_PERIOD_NS));
    localparam int MR_MIN_CYC = int'(ns_to_cycles(MR_MIN_NS, CLK_PERIOD_NS));
    localparam int REC_CYC    = int'(ns_to_cycles(REC_NS, CLK_PERIOD_NS));
    localparam int REC_W      = $clog2(REC_CYC + 2);
    localparam logic [REC_W-1:0] REC_V = REC_W'(REC_CYC);

    logic              en_short;
    logic              mr_short;
    logic              en_prev_q;
    logic [REC_W-1:0]  rec_cnt;
    logic              rec_bad;
    logic [VIOL_W-1:0] new_viol;

    quad_latch_pulse_chk #(.MIN_CYC(EN_MIN_CYC)) u_en_width (
        .clk     (clk),
        .rst     (rst),
        .level_n (en_n),
        .short_o (en_short)
    );

    quad_latch_pulse_chk #(.MIN_CYC(MR_MIN_CYC)) u_mr_width (
        .clk     (clk),
        .rst     (rst),
        .level_n (mrst_n),
        .short_o (mr_short)
    );

    // High samples of the master reset since it was last low
    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev_q <= 1'b1;
            rec_cnt   <= REC_V;
        end else begin
            en_prev_q <= en_n;
            if (!mrst_n)
                rec_cnt <= '0;
            else if (rec_cnt != REC_V)
                rec_cnt <= rec_cnt + REC_W'(1);
        end
    end

    assign rec_bad = !rst && en_prev_q && !en_n && mrst_n && (rec_cnt < REC_V);

    always_comb begin
        new_viol           = '0;
        new_viol[VIOL_EN]  = en_short;
        new_viol[VIOL_RST] = mr_short;
        new_viol[VIOL_REC] = rec_bad;
    end

    always_ff @(posedge clk) begin
        if (rst)
            viol_o <= '0;
        else if (viol_clr)
            viol_o <= new_viol;
        else
            viol_o <= viol_o | new_viol;
    end

    // R12
    viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !viol_clr |=> (($past(viol_o) & ~viol_o) == '0));

    // R12
    viol_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_clr && !en_short && !mr_short && !rec_bad) |=> (viol_o == '0));

endmodule

// File: rtl/quad_latch.sv
module quad_latch
    import quad_latch_pkg::*;
#(
    parameter int WIDTH         = 4,
    parameter int CLK_PERIOD_NS = 8,
    parameter int EN_MIN_NS     = 30,
    parameter int MR_MIN_NS     = 25,
    parameter int REC_NS        = 5,
    parameter int SYNC_STAGES   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mrst_n,
    input  logic             en_n,
    input  logic [WIDTH-1:0] d,
    input  logic [WIDTH-1:0] set_n,
    input  logic             viol_clr,
    output logic [WIDTH-1:0] q,
    output logic [2:0]       viol
);
    logic              clr_hold;
    logic [VIOL_W-1:0] viol_w;

    quad_latch_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk    (clk),
        .arst_n (mrst_n),
        .hold_o (clr_hold)
    );

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            bit_in_t bin;
            always_comb begin
                bin.en_n  = en_n;
                bin.d     = d[i];
                bin.set_n = set_n[i];
            end
            quad_latch_cell u_cell (
                .clk       (clk),
                .rst       (rst),
                .clr_async (clr_hold),
                .in_i      (bin),
                .q_o       (q[i])
            );
        end
    endgenerate

    quad_latch_timing_mon #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .EN_MIN_NS     (EN_MIN_NS),
        .MR_MIN_NS     (MR_MIN_NS),
        .REC_NS        (REC_NS)
    ) u_mon (
        .clk      (clk),
        .rst      (rst),
        .en_n     (en_n),
        .mrst_n   (mrst_n),
        .viol_clr (viol_clr),
        .viol_o   (viol_w)
    );

    assign viol = viol_w;

    // R7
    mreset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        !mrst_n |-> (q == '0));

endmodule

// File: tb/quad_latch_bench.sv
`timescale 1ns/1ps
module quad_latch_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst;
    logic         mrst_n;
    logic         en_n;
    logic [W-1:0] d;
    logic [W-1:0] set_n;
    logic         viol_clr;
    logic [W-1:0] q;
    logic [2:0]   viol;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    quad_latch u_quad_latch (
        .clk      (clk),
        .rst      (rst),
        .mrst_n   (mrst_n),
        .en_n     (en_n),
        .d        (d),
        .set_n    (set_n),
        .viol_clr (viol_clr),
        .q        (q),
        .viol     (viol)
    );

    always #4 clk = ~clk;

    // One rising edge, then park at the following falling edge
    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk_q(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            failures++;
            $display("FAIL %s: q=%h expected %h", req, q, exp);
        end
    endtask

    task automatic chk_v(input string req, input logic [2:0] exp);
        checks++;
        if (viol !== exp) begin
            failures++;
            $display("FAIL %s: viol=%b expected %b", req, viol, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic e,
                                              input logic [W-1:0] dv, input logic [W-1:0] sv);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            if (e)           r[i] = cur[i];
            else if (!dv[i]) r[i] = 1'b0;
            else if (!sv[i]) r[i] = 1'b1;
            else             r[i] = cur[i];
        end
        return r;
    endfunction

    task automatic clear_viol();
        viol_clr = 1'b1;
        step();
        viol_clr = 1'b0;
    endtask

    // Write a value in data-latch mode with a long enable pulse
    task automatic load(input logic [W-1:0] v);
        en_n = 1'b0; set_n = '0; d = v;
        step(4);
        en_n = 1'b1; d = ~v; set_n = ~v;
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1; mrst_n = 1'b0; en_n = 1'b1; d = '0; set_n = '1; viol_clr = 1'b0;
        step(5);
        mrst_n = 1'b1;
        step(3);
        rst = 1'b0;
        step();
        chk_q("R1", 4'h0);
        chk_v("R1", 3'b000);
    endtask

    task automatic t_hold();
        load(4'hA);
        chk_q("R3 load", 4'hA);
        en_n = 1'b1; d = 4'h5; set_n = 4'h0;
        step(2);
        chk_q("R2", 4'hA);
        d = 4'h0; set_n = 4'hF;
        step();
        chk_q("R2", 4'hA);
    endtask

    task automatic t_dmode();
        en_n = 1'b0; set_n = '0;
        d = 4'h3; step(); chk_q("R3", 4'h3);
        d = 4'hC; step(); chk_q("R3", 4'hC);
        d = 4'h9; step(); chk_q("R3", 4'h9);
        en_n = 1'b1; step();
    endtask

    task automatic t_set();
        load(4'h0);
        en_n = 1'b0; d = 4'hF; set_n = 4'b1010;
        step();
        chk_q("R4", 4'b0101);
        en_n = 1'b1; step(3);
    endtask

    task automatic t_dominant();
        load(4'hF);
        en_n = 1'b0; d = 4'b0110; set_n = 4'b0000;
        step();
        chk_q("R5", 4'b0110);
        en_n = 1'b1; step(3);
    endtask

    task automatic t_keep();
        load(4'b1001);
        en_n = 1'b0; d = 4'hF; set_n = 4'hF;
        step(2);
        chk_q("R6", 4'b1001);
        en_n = 1'b1; step(3);
    endtask

    task automatic t_mreset_async();
        load(4'hF);
        en_n = 1'b0; d = 4'hF; set_n = 4'h0;
        #1;
        mrst_n = 1'b0;
        #1;
        chk_q("R7", 4'h0);
        step(5);
        chk_q("R7", 4'h0);
        en_n = 1'b1;
        mrst_n = 1'b1;
        step(3);
    endtask

    task automatic t_release();
        load(4'h0);
        mrst_n = 1'b0; en_n = 1'b1;
        step(5);
        en_n = 1'b0; d = 4'hF; set_n = 4'h0;
        step();
        mrst_n = 1'b1;
        step(); chk_q("R8 edge1", 4'h0);
        step(); chk_q("R8 edge2", 4'h0);
        step(); chk_q("R8 edge3", 4'hF);
        step(2);
        en_n = 1'b1; step(2);
    endtask

    task automatic t_en_width();
        clear_viol();
        en_n = 1'b0; d = '1; set_n = '1; step(3);
        en_n = 1'b1; step();
        chk_v("R9 short", 3'b001);
        clear_viol();
        en_n = 1'b0; step(4);
        en_n = 1'b1; step();
        chk_v("R9 exact", 3'b000);
    endtask

    task automatic t_rst_width();
        clear_viol();
        mrst_n = 1'b0; step(3);
        mrst_n = 1'b1; step();
        chk_v("R10 short", 3'b010);
        step(3);
        clear_viol();
        mrst_n = 1'b0; step(4);
        mrst_n = 1'b1; step(3);
        chk_v("R10 exact", 3'b000);
    endtask

    task automatic t_recovery();
        clear_viol();
        en_n = 1'b1; mrst_n = 1'b0; step(5);
        mrst_n = 1'b1; en_n = 1'b0; step();
        chk_v("R11 same edge", 3'b100);
        step(5); en_n = 1'b1; step();
        clear_viol();
        mrst_n = 1'b0; step(5);
        mrst_n = 1'b1; step();
        en_n = 1'b0; step();
        chk_v("R11 one later", 3'b000);
        step(5); en_n = 1'b1; step();
        chk_v("R11 one later", 3'b000);
    endtask

    task automatic t_sticky();
        clear_viol();
        en_n = 1'b0; step();
        en_n = 1'b1; step();
        chk_v("R12 set", 3'b001);
        step(6);
        chk_v("R12 sticky", 3'b001);
        viol_clr = 1'b1; step(); viol_clr = 1'b0;
        chk_v("R12 clear", 3'b000);
    endtask

    task automatic t_random();
        logic [W-1:0] qm;
        load(4'h6);
        qm = 4'h6;
        for (int n = 0; n < 400; n++) begin
            en_n  = $urandom_range(0, 2) == 0;
            d     = W'($urandom);
            set_n = W'($urandom);
            if (n % 17 == 0) begin d = 4'h0; set_n = 4'h0; end
            qm = ref_next(qm, en_n, d, set_n);
            step();
            chk_q("R2-R6 random (R3 R4 R5 R6 R2)", qm);
        end
        en_n = 1'b1; step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_dmode();
        t_set();
        t_dominant();
        t_keep();
        t_mreset_async();
        t_release();
        t_en_width();
        t_rst_width();
        t_recovery();
        t_sticky();
        t_random();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        finish_run();
    end

endmodule